// File: doc/BRIEF.md
# Control Message Channel Encoder

This block turns one 32-bit downlink control word into a serial stream of exactly 144 coded bits. That is the capacity of two control channel elements. First a 16-bit CRC is computed over the word and XOR-masked with the 16-bit identifier of the addressed terminal. The masked CRC is appended to the word to form a 48-bit block. The block then passes through a rate-1/3, constraint-length-7 tail-biting convolutional code.

No rate matching is applied. The three parity outputs are read out bit by bit in a plain interleaved order, one parity triple per input bit. A start strobe captures the word and the identifier. The coded bits then leave one per ready/valid transfer, and the final bit is flagged.

Top module: `ctl_msg_encoder`

## Requirements
- R1: After reset deassertion, busy_o, valid_o and last_o are low.
- R2: Each accepted message produces exactly 144 transfers (valid_o and ready_i both high at a clock edge). last_o is high on the 144th transfer only.
- R3: The CRC uses polynomial x^16+x^12+x^5+1 with a zero initial value. It is computed over msg_i with bit 31 processed first. The 48-bit block is msg_i[31] down to msg_i[0], followed by (CRC XOR id_i) from bit 15 down to bit 0.
- R4: Coding uses generators 133, 171 and 165 (octal), with the MSB of each generator tapping the current input bit. The code is tail-biting: the register holding the six previous bits starts with block bits 47, 46, 45, 44, 43 and 42, in that order from newest to oldest.
- R5: The output order is parity 0, parity 1, parity 2 for block bit 0, then the same three for block bit 1, and so on through block bit 47.
- R6: The scheme index occupies msg_i[31:27]. The group bitmap occupies msg_i[26:2], with msg_i[26] selecting the lowest group of four resource blocks. mcs_err_o is high throughout the frame of a message whose index is 29, 30 or 31, and low for indices 0 to 28. The encoding itself is unaffected.
- R7: A start_i pulse while busy_o is high is ignored. The running frame is unchanged and no extra frame follows.
- R8: busy_o rises on the edge after start_i is accepted. It stays high until the edge that completes the last transfer, and is low on the following cycle.
- R9: While valid_o is high and ready_i is low, bit_o, valid_o and last_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; captures msg_i and id_i when idle |
| msg_i | input | 32 | Control message word |
| id_i | input | 16 | Terminal identifier used as the CRC mask |
| ready_i | input | 1 | Downstream ready |
| bit_o | output | 1 | Coded output bit |
| valid_o | output | 1 | bit_o is valid |
| last_o | output | 1 | Marks the 144th bit of a frame |
| busy_o | output | 1 | Frame in progress |
| mcs_err_o | output | 1 | Scheme index out of range for the current frame |

## Verification
The assertions check the following on every cycle:
- stalled outputs hold steady (R9);
- last_o never appears without valid_o (R2);
- busy_o falls right after the final transfer (R8);
- the captured block and the error flag cannot change mid-frame, so a start during a frame has no effect (R6, R7).

Only the bench scenarios can show that the bit values are right. The bench compares every frame with an independent model of the CRC, the masking, the tail-biting code and the readout order (R3, R4, R5). It also checks the frame length and the position of the last flag under random back-pressure.

// File: rtl/ctl_enc_pkg.sv
package ctl_enc_pkg;
  localparam int MSG_W  = 32;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam int BLK_W  = MSG_W + CRC_W;
  localparam int K_LEN  = 7;
  localparam int N_STR  = 3;
  localparam int IDX_W  = $clog2(BLK_W);
  localparam int SEL_W  = $clog2(N_STR);
  localparam int MCS_W  = 5;
  localparam int MCS_LSB = MSG_W - MCS_W;
  localparam int MCS_MAX = 28;
  // generator g: MSB taps current bit, LSB taps bit six back
  localparam logic [N_STR-1:0][K_LEN-1:0] GEN = {7'o165, 7'o171, 7'o133};
endpackage

// File: rtl/ctl_enc_crc.sv
module ctl_enc_crc
  import ctl_enc_pkg::*;
(
  input  logic [MSG_W-1:0] msg_i,
  input  logic [CRC_W-1:0] mask_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] acc;
  logic             fb;

  always_comb begin
    acc = '0;
    fb  = 1'b0;
    for (int i = MSG_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ msg_i[i];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ CRC_POLY;
    end
    crc_o = acc ^ mask_i;
  end
endmodule

// File: rtl/ctl_enc_conv.sv
module ctl_enc_conv
  import ctl_enc_pkg::*;
(
  input  logic [BLK_W-1:0] blk_i,   // blk_i[n] = block bit n
  input  logic [IDX_W-1:0] idx_i,
  output logic [N_STR-1:0] par_o
);
  logic [K_LEN-1:0] win;            // win[K_LEN-1] = current bit

  always_comb begin
    win = '0;
    for (int j = 0; j < K_LEN; j++) begin
      // circular index: tail-biting wraps to the block end
      if (int'(idx_i) >= j) win[K_LEN-1-j] = blk_i[int'(idx_i) - j];
      else                  win[K_LEN-1-j] = blk_i[int'(idx_i) + BLK_W - j];
    end
  end

  for (genvar g = 0; g < N_STR; g++) begin : g_par
    assign par_o[g] = ^(win & GEN[g]);
  end
endmodule

// File: rtl/ctl_enc_seq.sv
module ctl_enc_seq
  import ctl_enc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ready_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             load_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [SEL_W-1:0] sel_o
);
  logic busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [SEL_W-1:0] sel_q;
  logic xfer, end_idx, end_sel;

  assign end_idx = (idx_q == IDX_W'(BLK_W - 1));
  assign end_sel = (sel_q == SEL_W'(N_STR - 1));
  assign xfer    = busy_q & ready_i;
  assign load_o  = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sel_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      sel_q  <= '0;
    end else if (xfer) begin
      if (end_sel) begin
        sel_q <= '0;
        if (end_idx) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else begin
        sel_q <= sel_q + 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = busy_q;
  assign last_o  = busy_q & end_idx & end_sel;
  assign idx_o   = idx_q;
  assign sel_o   = sel_q;

  AST_LAST_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);  // R2
  AST_STALL_HOLDS_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(idx_q) && $stable(sel_q)));  // R9
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && last_o) |=> !busy_o);  // R8
endmodule

// File: rtl/ctl_msg_encoder.sv
module ctl_msg_encoder
  import ctl_enc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [MSG_W-1:0] msg_i,
  input  logic [CRC_W-1:0] id_i,
  input  logic             ready_i,
  output logic             bit_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             busy_o,
  output logic             mcs_err_o
);
  logic [CRC_W-1:0] crc_m;
  logic [BLK_W-1:0] blk_d, blk_q;
  logic [N_STR-1:0] par;
  logic [IDX_W-1:0] idx;
  logic [SEL_W-1:0] sel;
  logic load, err_q;

  ctl_enc_crc u_crc (.msg_i(msg_i), .mask_i(id_i), .crc_o(crc_m));

  // block bit n: message MSB first, then masked CRC MSB first
  always_comb begin
    for (int n = 0; n < MSG_W; n++) blk_d[n] = msg_i[MSG_W-1-n];
    for (int n = 0; n < CRC_W; n++) blk_d[MSG_W+n] = crc_m[CRC_W-1-n];
  end

  ctl_enc_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ready_i(ready_i),
    .busy_o(busy_o), .valid_o(valid_o), .last_o(last_o), .load_o(load),
    .idx_o(idx), .sel_o(sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q <= '0;
      err_q <= 1'b0;
    end else if (load) begin
      blk_q <= blk_d;
      err_q <= (int'(msg_i[MSG_W-1:MCS_LSB]) > MCS_MAX);
    end
  end

  ctl_enc_conv u_conv (.blk_i(blk_q), .idx_i(idx), .par_o(par));

  assign bit_o     = par[sel];
  assign mcs_err_o = busy_o & err_q;

  AST_BLOCK_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(blk_q));  // R7
  AST_ERR_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mcs_err_o));  // R6
  AST_BIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> $stable(bit_o));  // R9
endmodule

// File: tb/ctl_msg_encoder_bench.sv
`timescale 1ns/1ps
module ctl_msg_encoder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ready = 1'b0;
  logic [31:0] msg = '0;
  logic [15:0] id = '0;
  logic bit_w, valid, last, busy, err;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctl_msg_encoder u_ctl_msg_encoder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .msg_i(msg), .id_i(id),
    .ready_i(ready), .bit_o(bit_w), .valid_o(valid), .last_o(last),
    .busy_o(busy), .mcs_err_o(err)
  );

  function automatic logic [143:0] ref_enc(logic [31:0] m, logic [15:0] r);
    logic [15:0] c = '0;
    logic [47:0] b;
    logic [5:0] sr;
    logic [6:0] g [3];
    logic [143:0] o = '0;
    g[0] = 7'o133; g[1] = 7'o171; g[2] = 7'o165;
    for (int i = 31; i >= 0; i--) begin
      logic f = c[15] ^ m[i];
      c = {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
    end
    c = c ^ r;
    for (int n = 0; n < 32; n++) b[n] = m[31-n];
    for (int n = 0; n < 16; n++) b[32+n] = c[15-n];
    for (int j = 1; j <= 6; j++) sr[j-1] = b[48-j];  // sr[j-1] = bit j back
    for (int k = 0; k < 48; k++) begin
      for (int s = 0; s < 3; s++) begin
        logic p = g[s][6] & b[k];
        for (int j = 1; j <= 6; j++) p ^= g[s][6-j] & sr[j-1];
        o[3*k+s] = p;
      end
      sr = {sr[4:0], b[k]};
    end
    return o;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [143:0] act, logic [143:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(logic [31:0] m, logic [15:0] r, int rdy_pct, bit poke);
    logic [143:0] got = '0, exp;
    int cnt = 0, last_at = -1, guard = 0;
    bit err_bad = 1'b0, hold_bad = 1'b0, prev_stall = 1'b0, prev_bit = 1'b0;
    exp = ref_enc(m, r);
    @(negedge clk);
    msg = m; id = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    msg = ~m; id = ~r;
    #1;
    chk(busy === 1'b1, "R8", "busy after accept", 144'(busy), 144'd1);
    chk(err === (m[31:27] > 5'd28), "R6", "mcs_err_o", 144'(err), 144'(m[31:27] > 5'd28));
    while (busy && guard < 3000) begin
      guard++;
      ready = ($urandom_range(99) < rdy_pct);
      if (poke && cnt == 70) start = 1'b1;
      #1;
      if (prev_stall && bit_w !== prev_bit) hold_bad = 1'b1;
      if (err !== (m[31:27] > 5'd28)) err_bad = 1'b1;
      if (valid && ready) begin
        if (cnt < 144) got[cnt] = bit_w;
        if (last) last_at = cnt;
        cnt++;
      end
      prev_stall = valid & ~ready;
      prev_bit = bit_w;
      @(negedge clk);
      start = 1'b0;
    end
    ready = 1'b0;
    if (guard >= 3000) chk(1'b0, "R8", "frame hung", 144'(cnt), 144'd144);
    chk(cnt == 144, "R2", "transfer count", 144'(cnt), 144'd144);
    chk(last_at == 143, "R2", "last position", 144'(last_at), 144'd143);
    chk(got === exp, "R3 R4 R5", "coded bits", got, exp);
    chk(!err_bad, "R6", "flag steady in frame", 144'(err_bad), 144'd0);
    chk(!hold_bad, "R9", "bit held in stall", 144'(hold_bad), 144'd0);
    #1;
    chk(busy === 1'b0 && valid === 1'b0, "R8", "idle after last", 144'(busy), 144'd0);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy === 1'b0, "R7", "no extra frame", 144'(busy), 144'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!busy && !valid && !last, "R1", "reset state", 144'({busy, valid, last}), 144'd0);
    run_frame(32'h0000_0000, 16'h0000, 100, 1'b0);           // all zero
    run_frame(32'hFFFF_FFFF, 16'hFFFF, 100, 1'b0);           // R6 index 31
    run_frame({5'd28, 25'h1FF_FFFF, 2'b00}, 16'h1234, 60, 1'b0); // R6 max legal
    run_frame({5'd29, 25'h000_0001, 2'b00}, 16'hBEEF, 50, 1'b0); // R6 first illegal
    run_frame(32'h8000_0001, 16'h8001, 30, 1'b1);            // R7 start while busy
    for (int i = 0; i < 12; i++)
      run_frame($urandom, 16'($urandom), 20 + 7 * i, i[0]);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule